// File: doc/BRIEF.md
# Receive Word Readout with Lead and Tail Zero Padding

This block sits on the read side of a receive data store. An upstream packer pushes 32-bit data words into a word FIFO, with the first received byte in bits 7:0 and a CRC word after each frame's data. For every frame, it also pushes a word count into a separate length queue. Software-facing logic then issues single-word read requests, and the block serves them one packet at a time.

When a packet starts, the block latches a lead count of zero words and an end-alignment mode from its configuration inputs. Each read returns one lead zero word while any remain, then the packet's data words in push order, then zero tail words until lead plus data plus tail reaches the chosen alignment. A skip command drops what is left of the current packet, or of the next packet if none is open. A dump command flushes both stores. A read with nothing left to return produces a zero word and an underflow pulse.

Top module: `rxro_readout`

## Requirements
- R1: After reset, rd_valid, underflow and fifo_full are 0, fifo_used is 0 and lenq_full is 0.
- R2: A read or skip that arrives while no packet is open removes the head entry of the length queue. A nonzero count opens a packet of that many data words. A zero count is removed without opening a packet.
- R3: When a packet opens, cfg_lead_words (0 to 7) is latched and that many zero words are returned before its first data word. Changing cfg_lead_words later has no effect on the open packet.
- R4: Each rd_req is answered on the next clock edge with rd_valid=1. A lead word is returned while any remain, else a data word popped from the FIFO, else a tail pad word of zero. No rd_valid appears without a request.
- R5: cfg_end_align is latched at packet open. 1 pads lead+data words up to a multiple of 4, 2 pads up to a multiple of 8, and 0 or 3 adds no tail words.
- R6: A read when the packet has no lead, data or tail words left, and no nonzero entry can be opened, returns rd_word=0 with rd_valid=1 and underflow=1 for one cycle.
- R7: skip_req discards the remaining data words of the open packet and clears its lead and tail counts. If no packet is open, the next one is opened and all of its data words are discarded. A skip gives no rd_valid.
- R8: dump_req empties the word FIFO and the length queue and closes any open packet. fifo_used is 0 in the next cycle.
- R9: fifo_used counts the stored words. fifo_full is 1 when it equals 2**DATA_AW, and a push while full is refused.
- R10: The length queue holds 2**LENQ_AW counts in a circular buffer. lenq_full is 1 when it is full, and a count pushed while full is dropped.
- R11: On a single edge, dump_req takes priority over skip_req, and skip_req takes priority over rd_req. The lower-priority request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lead_words | input | 3 | Lead zero words per packet |
| cfg_end_align | input | 2 | End alignment mode (0/3 none, 1 four, 2 eight) |
| wr_valid | input | 1 | Push a data word |
| wr_word | input | 32 | Data word to push |
| len_valid | input | 1 | Push a packet word count |
| len_words | input | DATA_AW+1 | Packet data word count |
| rd_req | input | 1 | Read one word |
| skip_req | input | 1 | Drop rest of packet |
| dump_req | input | 1 | Flush both stores |
| rd_valid | output | 1 | Read response valid |
| rd_word | output | 32 | Read response word |
| underflow | output | 1 | Read found nothing to return |
| fifo_used | output | DATA_AW+1 | Words held in the FIFO |
| fifo_full | output | 1 | FIFO full |
| lenq_full | output | 1 | Length queue full |

## Verification
One packet with no lead and no alignment checks plain data order and the underflow after it. Packets with a lead and align modes 1, 2 and 3 separate lead, data and tail counting, and a mid-packet configuration change shows whether the lead count is latched. Zero-count entries, skips with a packet open and with none open, and requests issued together check the queue-consumption rules and the request priority. A FIFO and a length queue filled past capacity show whether pushes while full are refused.

// File: rtl/rxro_pkg.sv
package rxro_pkg;
  typedef enum logic [1:0] {
    ALN_NONE = 2'd0,
    ALN_4    = 2'd1,
    ALN_8    = 2'd2,
    ALN_RSVD = 2'd3
  } align_e;

  // Tail words needed so lead+data lands on the chosen boundary.
  function automatic logic [2:0] tail_pad(input logic [1:0] mode,
                                          input logic [2:0] lead,
                                          input logic [2:0] words_lo);
    logic [2:0] sum;
    sum = lead + words_lo;
    case (mode)
      ALN_4:   tail_pad = (3'd0 - sum) & 3'd3;
      ALN_8:   tail_pad = 3'd0 - sum;
      default: tail_pad = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rxro_word_fifo.sv
module rxro_word_fifo #(
  parameter int AW     = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push_en,
  input  logic [WORD_W-1:0] push_word,
  input  logic              rd_sel,
  input  logic [AW:0]       adv_n,
  output logic [WORD_W-1:0] rd_q,
  output logic [AW:0]       used,
  output logic              full
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       used_q;
  logic              push_ok;

  assign full    = (used_q == (AW+1)'(DEPTH));
  assign push_ok = push_en && !full && !clr;
  assign used    = used_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  // Output register with synchronous zeroing, block RAM friendly.
  always_ff @(posedge clk) begin
    if (rst || !rd_sel) rd_q <= '0;
    else                rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + adv_n[AW-1:0];
      used_q <= used_q + {{AW{1'b0}}, push_ok} - adv_n;
    end
  end
endmodule

// File: rtl/rxro_len_queue.sv
module rxro_len_queue #(
  parameter int QAW   = 10,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push_en,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic             nonempty,
  output logic             full
);
  localparam int QDEPTH = 1 << QAW;

  logic [LEN_W-1:0] ring [QDEPTH];
  logic [QAW-1:0]   head_q, tail_q;
  logic [QAW:0]     cnt_q;
  logic             push_ok, pop_ok;

  assign full     = (cnt_q == (QAW+1)'(QDEPTH));
  assign nonempty = (cnt_q != '0);
  assign push_ok  = push_en && !full && !clr;
  assign pop_ok   = pop && nonempty && !clr;
  assign head_len = ring[head_q];

  always_ff @(posedge clk) begin
    if (push_ok) ring[tail_q] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) tail_q <= tail_q + 1'b1;
      if (pop_ok)  head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + {{QAW{1'b0}}, push_ok} - {{QAW{1'b0}}, pop_ok};
    end
  end
endmodule

// File: rtl/rxro_pkt_seq.sv
module rxro_pkt_seq
  import rxro_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_lead_words,
  input  logic [1:0]       cfg_end_align,
  input  logic             rd_req,
  input  logic             skip_req,
  input  logic             dump_req,
  input  logic             q_nonempty,
  input  logic [LEN_W-1:0] q_len,
  output logic             q_pop,
  output logic [LEN_W-1:0] adv_n,
  output logic             data_sel,
  output logic             rd_valid,
  output logic             underflow
);
  logic [2:0]       lead_q, pad_q, eff_lead, eff_pad;
  logic [LEN_W-1:0] size_q, eff_size;
  logic             idle, opening, do_skip, do_read;

  assign idle    = (lead_q == '0) && (size_q == '0) && (pad_q == '0);
  assign do_skip = skip_req && !dump_req;
  assign do_read = rd_req && !skip_req && !dump_req;
  assign q_pop   = idle && q_nonempty && (do_skip || do_read);
  assign opening = q_pop && (q_len != '0);

  always_comb begin
    if (opening) begin
      eff_lead = cfg_lead_words;
      eff_size = q_len;
      eff_pad  = tail_pad(cfg_end_align, cfg_lead_words, q_len[2:0]);
    end else begin
      eff_lead = lead_q;
      eff_size = size_q;
      eff_pad  = pad_q;
    end
  end

  assign data_sel = do_read && (eff_lead == '0) && (eff_size != '0);

  always_comb begin
    adv_n = '0;
    if (do_skip)       adv_n = eff_size;
    else if (data_sel) adv_n = LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || dump_req) begin
      lead_q    <= '0;
      size_q    <= '0;
      pad_q     <= '0;
      rd_valid  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      rd_valid  <= do_read;
      underflow <= 1'b0;
      if (do_skip) begin
        lead_q <= '0;
        size_q <= '0;
        pad_q  <= '0;
      end else if (do_read) begin
        lead_q <= eff_lead;
        size_q <= eff_size;
        pad_q  <= eff_pad;
        if (eff_lead != '0)      lead_q <= eff_lead - 3'd1;
        else if (eff_size != '0) size_q <= eff_size - LEN_W'(1);
        else if (eff_pad != '0)  pad_q  <= eff_pad - 3'd1;
        else                     underflow <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxro_readout.sv
module rxro_readout #(
  parameter int DATA_AW = 6,
  parameter int LENQ_AW = 10,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cfg_lead_words,
  input  logic [1:0]         cfg_end_align,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               len_valid,
  input  logic [DATA_AW:0]   len_words,
  input  logic               rd_req,
  input  logic               skip_req,
  input  logic               dump_req,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_word,
  output logic               underflow,
  output logic [DATA_AW:0]   fifo_used,
  output logic               fifo_full,
  output logic               lenq_full
);
  localparam int LEN_W = DATA_AW + 1;

  logic             q_nonempty, q_pop, data_sel;
  logic [LEN_W-1:0] q_len, adv_n;

  rxro_word_fifo #(.AW(DATA_AW), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(dump_req),
    .push_en(wr_valid), .push_word(wr_word),
    .rd_sel(data_sel), .adv_n(adv_n),
    .rd_q(rd_word), .used(fifo_used), .full(fifo_full)
  );

  rxro_len_queue #(.QAW(LENQ_AW), .LEN_W(LEN_W)) u_lenq (
    .clk(clk), .rst(rst), .clr(dump_req),
    .push_en(len_valid), .push_len(len_words),
    .pop(q_pop), .head_len(q_len),
    .nonempty(q_nonempty), .full(lenq_full)
  );

  rxro_pkt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst),
    .cfg_lead_words(cfg_lead_words), .cfg_end_align(cfg_end_align),
    .rd_req(rd_req), .skip_req(skip_req), .dump_req(dump_req),
    .q_nonempty(q_nonempty), .q_len(q_len), .q_pop(q_pop),
    .adv_n(adv_n), .data_sel(data_sel),
    .rd_valid(rd_valid), .underflow(underflow)
  );
endmodule

// File: rtl/rxro_readout_chk.sv
module rxro_readout_chk #(
  parameter int DATA_AW = 6,
  parameter int WORD_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              rd_req,
  input logic              skip_req,
  input logic              dump_req,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_word,
  input logic              underflow,
  input logic [DATA_AW:0]  fifo_used,
  input logic              fifo_full
);
  localparam int DEPTH = 1 << DATA_AW;

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_used <= (DATA_AW+1)'(DEPTH)); // R9
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
    fifo_full && wr_valid && !rd_req && !skip_req && !dump_req
      |=> fifo_used == $past(fifo_used)); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    rd_req && !skip_req && !dump_req |=> rd_valid); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid); // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    underflow |-> rd_valid && rd_word == '0); // R6
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    skip_req |=> !rd_valid); // R7
  AST_DUMP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dump_req |=> fifo_used == '0 && !fifo_full); // R8
endmodule

bind rxro_readout rxro_readout_chk #(.DATA_AW(DATA_AW), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_req(rd_req),
  .skip_req(skip_req), .dump_req(dump_req), .rd_valid(rd_valid),
  .rd_word(rd_word), .underflow(underflow), .fifo_used(fifo_used),
  .fifo_full(fifo_full)
);

// File: tb/rxro_readout_test.sv
`timescale 1ns/1ps
module rxro_readout_test;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int QD    = 1 << 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_lead_words = '0;
  logic [1:0]  cfg_end_align = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        len_valid = 1'b0;
  logic [AW:0] len_words = '0;
  logic        rd_req = 1'b0, skip_req = 1'b0, dump_req = 1'b0;
  logic        rd_valid, underflow, fifo_full, lenq_full;
  logic [31:0] rd_word;
  logic [AW:0] fifo_used;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxro_readout uut (
    .clk(clk), .rst(rst), .cfg_lead_words(cfg_lead_words),
    .cfg_end_align(cfg_end_align), .wr_valid(wr_valid), .wr_word(wr_word),
    .len_valid(len_valid), .len_words(len_words), .rd_req(rd_req),
    .skip_req(skip_req), .dump_req(dump_req), .rd_valid(rd_valid),
    .rd_word(rd_word), .underflow(underflow), .fifo_used(fifo_used),
    .fifo_full(fifo_full), .lenq_full(lenq_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic push_len(input int n);
    @(negedge clk); len_valid = 1'b1; len_words = (AW+1)'(n);
    @(negedge clk); len_valid = 1'b0;
  endtask

  task automatic op(input bit r, input bit s, input bit d);
    @(negedge clk); rd_req = r; skip_req = s; dump_req = d;
    @(negedge clk); rd_req = 1'b0; skip_req = 1'b0; dump_req = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [31:0] exp_w, input bit exp_unf);
    op(1, 0, 0);
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " word"}, rd_word, exp_w);
    check({req, " underflow"}, 32'(underflow), 32'(exp_unf));
  endtask

  task automatic t_reset;
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 underflow", 32'(underflow), 0);
    check("R1 used", 32'(fifo_used), 0);
    check("R1 full", 32'(fifo_full), 0);
    check("R1 lenq_full", 32'(lenq_full), 0);
  endtask

  task automatic t_plain;
    op(0, 0, 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    for (int i = 0; i < 3; i++) push_word(32'hA000_0000 + i);
    push_len(3);
    for (int i = 0; i < 3; i++) read_chk("R4 plain data", 32'hA000_0000 + i, 0);
    read_chk("R6 underflow after packet", 0, 1);
    op(0, 0, 0);
    check("R4 no response without request", 32'(rd_valid), 0);
  endtask

  task automatic t_lead_align4;
    op(0, 0, 1);
    cfg_lead_words = 2; cfg_end_align = 1;
    for (int i = 0; i < 3; i++) push_word(32'hB000_0010 + i);
    push_len(3);
    read_chk("R3 lead word 0", 0, 0);
    cfg_lead_words = 0; cfg_end_align = 0;
    read_chk("R3 lead latched", 0, 0);
    for (int i = 0; i < 3; i++) read_chk("R4 data after lead", 32'hB000_0010 + i, 0);
    for (int i = 0; i < 3; i++) read_chk("R5 align4 tail", 0, 0);
    read_chk("R6 underflow after tail", 0, 1);
  endtask

  task automatic t_align8_and_3;
    op(0, 0, 1);
    cfg_lead_words = 1; cfg_end_align = 2;
    push_word(32'hC1); push_word(32'hC2); push_len(2);
    read_chk("R3 lead align8", 0, 0);
    read_chk("R4 data c1", 32'hC1, 0);
    read_chk("R4 data c2", 32'hC2, 0);
    for (int i = 0; i < 5; i++) read_chk("R5 align8 tail", 0, 0);
    read_chk("R5 align8 end", 0, 1);
    cfg_lead_words = 1; cfg_end_align = 3;
    push_word(32'hC3); push_len(1);
    read_chk("R5 mode3 lead", 0, 0);
    read_chk("R5 mode3 data", 32'hC3, 0);
    read_chk("R5 mode3 no tail", 0, 1);
  endtask

  task automatic t_zero_len;
    op(0, 0, 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    push_len(0);
    push_word(32'hD00D); push_len(1);
    read_chk("R2 zero count no packet", 0, 1);
    read_chk("R2 next packet opens", 32'hD00D, 0);
  endtask

  task automatic t_skip_open;
    op(0, 0, 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    for (int i = 0; i < 4; i++) push_word(32'hE000 + i);
    push_len(4);
    push_word(32'hF000); push_word(32'hF001); push_len(2);
    read_chk("R7 first word", 32'hE000, 0);
    op(0, 1, 0);
    check("R7 skip no response", 32'(rd_valid), 0);
    check("R7 skip drops rest", 32'(fifo_used), 2);
    read_chk("R7 next packet", 32'hF000, 0);
    read_chk("R7 next packet w1", 32'hF001, 0);
  endtask

  task automatic t_skip_idle;
    op(0, 0, 1);
    cfg_lead_words = 3; cfg_end_align = 1;
    for (int i = 0; i < 3; i++) push_word(32'h1100 + i);
    push_len(3);
    push_word(32'h2200); push_len(1);
    op(0, 1, 0);
    check("R7 idle skip drops packet", 32'(fifo_used), 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    read_chk("R7 lead and tail cleared", 32'h2200, 0);
  endtask

  task automatic t_full_dump;
    op(0, 0, 1);
    for (int i = 0; i < DEPTH + 2; i++) push_word(32'h5000 + i);
    check("R9 used at capacity", 32'(fifo_used), DEPTH);
    check("R9 full flag", 32'(fifo_full), 1);
    push_len(DEPTH + 0);
    cfg_lead_words = 0; cfg_end_align = 0;
    read_chk("R9 oldest kept", 32'h5000, 0);
    check("R9 not full after pop", 32'(fifo_full), 0);
    op(0, 0, 1);
    check("R8 dump empties", 32'(fifo_used), 0);
    read_chk("R8 dump closes packet", 0, 1);
  endtask

  task automatic t_priority;
    op(0, 0, 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    push_word(32'h77); push_len(1);
    op(1, 1, 0);
    check("R11 skip over read", 32'(rd_valid), 0);
    check("R11 skip applied", 32'(fifo_used), 0);
    push_word(32'h78); push_len(1);
    op(1, 1, 1);
    check("R11 dump over all", 32'(rd_valid), 0);
    check("R11 dump applied", 32'(fifo_used), 0);
    read_chk("R11 queue dumped", 0, 1);
  endtask

  task automatic t_lenq_full;
    op(0, 0, 1);
    cfg_lead_words = 0; cfg_end_align = 0;
    @(negedge clk); len_valid = 1'b1; len_words = '0;
    repeat (QD) @(negedge clk);
    len_valid = 1'b0;
    check("R10 lenq full", 32'(lenq_full), 1);
    push_len(1);
    push_word(32'h99);
    @(negedge clk); rd_req = 1'b1;
    repeat (QD) @(negedge clk);
    rd_req = 1'b0;
    check("R10 queue drained", 32'(lenq_full), 0);
    read_chk("R10 count pushed while full dropped", 0, 1);
    op(0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_lead_align4();
    t_align8_and_3();
    t_zero_len();
    t_skip_open();
    t_skip_idle();
    t_full_dump();
    t_priority();
    t_lenq_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule